// File: doc/BRIEF.md
# Transport Stream Sync Lock Detector

This block takes a raw byte stream of fixed-length transport packets and works out where the packets start. It looks for a programmable sync token that repeats at a programmable packet spacing. It declares lock after a programmed number of consecutive hits. Once locked, it keeps its position and only gives up lock after a programmed number of consecutive misses. This hysteresis means one corrupted sync byte does not cost a packet boundary.

Bytes are passed downstream only while the block is locked. Each packet's first byte is flagged as start of packet and its last byte as end of packet, so the consumer always receives whole packets. Bytes are passed through unchanged, with the most significant bit on bit 7.

Internally the block walks through three phases: hunting for any token, verifying repeats at the expected spacing, and locked. A position counter runs across all three.

Top module: `ts_sync_lock`

## Requirements
- R1: During and right after reset, locked_o, valid_o, sop_o and eop_o are 0.
- R2: While hunting, bytes that differ from token_i do not start verification, produce no output and never lead to lock. A byte equal to token_i starts verification and counts as the first hit.
- R3: Lock is declared on the byte that completes lock_cnt_i consecutive token hits spaced pkt_len_i valid bytes apart. locked_o is 1 from the clock edge that takes that byte. A lock_cnt_i of 0 behaves like 1.
- R4: During verification, a byte other than token_i at the expected position sends the block back to hunting with the hit count discarded. Lock then needs a full new run of lock_cnt_i hits.
- R5: Every byte accepted while locked appears unchanged on data_o, with valid_o high, one clock after it was presented.
- R6: sop_o is high with the byte at each expected sync position. eop_o is high with the byte pkt_len_i-1 positions after it. The two are never high together, and neither is high without valid_o.
- R7: The first byte output is the sync byte that completes lock, so the first output packet is complete. valid_o is never high while locked_o is 0.
- R8: While locked, each non-token byte at an expected position adds a miss, and each token byte clears the miss count. The byte that brings the miss count to drop_cnt_i (0 behaves like 1) ends lock and is not output. Bytes at missed positions before that point are still output, flagged as sop.
- R9: Cycles with valid_i low are ignored, whatever byte_i holds: they do not advance the position and produce no output.
- R10: The token value and the packet length are taken from token_i and pkt_len_i (at least 2). The defaults are 0x47, 188 bytes, and 9 for both counts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| byte_i | input | DATA_W | Incoming stream byte |
| valid_i | input | 1 | byte_i carries a stream byte this cycle |
| token_i | input | DATA_W | Sync token value |
| lock_cnt_i | input | CNT_W | Consecutive hits needed to lock |
| drop_cnt_i | input | CNT_W | Consecutive misses that end lock |
| pkt_len_i | input | LEN_W | Packet length in bytes |
| data_o | output | DATA_W | Output byte |
| valid_o | output | 1 | data_o holds a packet byte |
| sop_o | output | 1 | data_o is the first byte of a packet |
| eop_o | output | 1 | data_o is the last byte of a packet |
| locked_o | output | 1 | Packet alignment is locked |

## Verification
A wrong internal state shows up at the ports within one packet. A stuck or off-by-one position counter moves sop_o and eop_o away from the bytes the bench expects, or moves the byte index at which locked_o rises. A hit or miss counter that does not clear, or that saturates wrongly, shifts the lock or drop edge by a whole packet. That shows as a rise or fall index that is wrong by exactly pkt_len_i bytes.

The bench also sends idle cycles that carry the token value. A block that counts them breaks the packet spacing. The per-byte comparison then reports misaligned markers from the next packet on.

// File: rtl/ts_sync_pkg.sv
package ts_sync_pkg;
  typedef enum logic [1:0] {
    ST_HUNT   = 2'd0,
    ST_VERIFY = 2'd1,
    ST_LOCKED = 2'd2
  } sync_state_e;

  localparam logic [7:0] DEF_TOKEN    = 8'h47;
  localparam int         DEF_PKT_LEN  = 188;
  localparam int         DEF_LOCK_CNT = 9;
  localparam int         DEF_DROP_CNT = 9;
endpackage

// File: rtl/ts_sync_pos.sv
module ts_sync_pos #(
  parameter int LEN_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             adv_i,
  input  logic             restart_i,
  output logic [LEN_W-1:0] pos_o
);
  localparam logic [LEN_W-1:0] POS_ONE = LEN_W'(1);
  localparam logic [LEN_W-1:0] POS_MAX = '1;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                           pos_o <= '0;
    else if (restart_i)                    pos_o <= POS_ONE;
    else if (adv_i && (pos_o != POS_MAX))  pos_o <= pos_o + POS_ONE;
  end
endmodule

// File: rtl/ts_sync_fsm.sv
module ts_sync_fsm
  import ts_sync_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int LEN_W  = 8,
  parameter int CNT_W  = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              valid_i,
  input  logic [DATA_W-1:0] byte_i,
  input  logic [DATA_W-1:0] token_i,
  input  logic [CNT_W-1:0]  lock_cnt_i,
  input  logic [CNT_W-1:0]  drop_cnt_i,
  input  logic [LEN_W-1:0]  pkt_len_i,
  input  logic [LEN_W-1:0]  pos_i,
  output logic              restart_o,
  output logic              emit_o,
  output logic              sop_o,
  output logic              eop_o,
  output logic              locked_o
);
  localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);
  localparam logic [LEN_W-1:0] LEN_ONE = LEN_W'(1);

  sync_state_e      state_q, state_d;
  logic [CNT_W-1:0] hit_q, hit_d, miss_q, miss_d;
  logic [CNT_W:0]   hit_inc, miss_inc;
  logic [CNT_W-1:0] lock_eff, drop_eff;
  logic             is_tok, at_exp, at_last, lock_now, drop_now;

  assign is_tok   = (byte_i == token_i);
  assign at_exp   = (pos_i == pkt_len_i);
  assign at_last  = (pos_i == pkt_len_i - LEN_ONE);
  assign lock_eff = (lock_cnt_i == '0) ? CNT_ONE : lock_cnt_i;
  assign drop_eff = (drop_cnt_i == '0) ? CNT_ONE : drop_cnt_i;
  assign hit_inc  = {1'b0, hit_q} + (CNT_W+1)'(1);
  assign miss_inc = {1'b0, miss_q} + (CNT_W+1)'(1);

  always_comb begin
    state_d   = state_q;
    hit_d     = hit_q;
    miss_d    = miss_q;
    restart_o = 1'b0;
    lock_now  = 1'b0;
    drop_now  = 1'b0;
    unique case (state_q)
      ST_HUNT: begin
        if (valid_i && is_tok) begin
          restart_o = 1'b1;
          hit_d     = CNT_ONE;
          miss_d    = '0;
          if (lock_eff == CNT_ONE) begin
            state_d  = ST_LOCKED;
            lock_now = 1'b1;
          end else begin
            state_d = ST_VERIFY;
          end
        end
      end
      ST_VERIFY: begin
        if (valid_i && at_exp) begin
          if (is_tok) begin
            restart_o = 1'b1;
            hit_d     = hit_inc[CNT_W-1:0];
            if (hit_inc >= {1'b0, lock_eff}) begin
              state_d  = ST_LOCKED;
              lock_now = 1'b1;
              miss_d   = '0;
            end
          end else begin
            state_d = ST_HUNT;
            hit_d   = '0;
          end
        end
      end
      ST_LOCKED: begin
        if (valid_i && at_exp) begin
          if (is_tok) begin
            restart_o = 1'b1;
            miss_d    = '0;
          end else if (miss_inc >= {1'b0, drop_eff}) begin
            state_d  = ST_HUNT;
            drop_now = 1'b1;
            miss_d   = '0;
            hit_d    = '0;
          end else begin
            restart_o = 1'b1;
            miss_d    = miss_inc[CNT_W-1:0];
          end
        end
      end
      default: state_d = ST_HUNT;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_HUNT;
      hit_q   <= '0;
      miss_q  <= '0;
    end else begin
      state_q <= state_d;
      hit_q   <= hit_d;
      miss_q  <= miss_d;
    end
  end

  assign locked_o = (state_q == ST_LOCKED);
  assign emit_o   = valid_i && ((locked_o && !drop_now) || lock_now);
  assign sop_o    = emit_o && (lock_now || at_exp);
  assign eop_o    = emit_o && locked_o && at_last && !at_exp;

  AST_LOCK_ON_TOKEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(locked_o) |-> $past(valid_i && (byte_i == token_i)));  // R3
  AST_DROP_ON_MISS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(locked_o) |-> $past(valid_i && (byte_i != token_i)));  // R8
  AST_IDLE_HOLDS_STATE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> $stable(locked_o));  // R9
endmodule

// File: rtl/ts_sync_out.sv
module ts_sync_out #(
  parameter int DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              emit_i,
  input  logic              sop_i,
  input  logic              eop_i,
  input  logic [DATA_W-1:0] byte_i,
  output logic [DATA_W-1:0] data_o,
  output logic              valid_o,
  output logic              sop_o,
  output logic              eop_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      data_o  <= '0;
      valid_o <= 1'b0;
      sop_o   <= 1'b0;
      eop_o   <= 1'b0;
    end else begin
      valid_o <= emit_i;
      sop_o   <= sop_i;
      eop_o   <= eop_i;
      if (emit_i) data_o <= byte_i;
    end
  end

  AST_MARK_NEEDS_VALID: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sop_o || eop_o) |-> valid_o);  // R6
  AST_SOP_EOP_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(sop_o && eop_o));  // R6
endmodule

// File: rtl/ts_sync_lock.sv
module ts_sync_lock #(
  parameter int DATA_W = 8,
  parameter int LEN_W  = 8,
  parameter int CNT_W  = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [DATA_W-1:0] byte_i,
  input  logic              valid_i,
  input  logic [DATA_W-1:0] token_i,
  input  logic [CNT_W-1:0]  lock_cnt_i,
  input  logic [CNT_W-1:0]  drop_cnt_i,
  input  logic [LEN_W-1:0]  pkt_len_i,
  output logic [DATA_W-1:0] data_o,
  output logic              valid_o,
  output logic              sop_o,
  output logic              eop_o,
  output logic              locked_o
);
  logic [LEN_W-1:0] pos;
  logic             restart, emit, sop_c, eop_c;

  ts_sync_pos #(.LEN_W(LEN_W)) u_pos (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .adv_i     (valid_i),
    .restart_i (restart),
    .pos_o     (pos)
  );

  ts_sync_fsm #(.DATA_W(DATA_W), .LEN_W(LEN_W), .CNT_W(CNT_W)) u_fsm (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .valid_i    (valid_i),
    .byte_i     (byte_i),
    .token_i    (token_i),
    .lock_cnt_i (lock_cnt_i),
    .drop_cnt_i (drop_cnt_i),
    .pkt_len_i  (pkt_len_i),
    .pos_i      (pos),
    .restart_o  (restart),
    .emit_o     (emit),
    .sop_o      (sop_c),
    .eop_o      (eop_c),
    .locked_o   (locked_o)
  );

  ts_sync_out #(.DATA_W(DATA_W)) u_out (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .emit_i  (emit),
    .sop_i   (sop_c),
    .eop_i   (eop_c),
    .byte_i  (byte_i),
    .data_o  (data_o),
    .valid_o (valid_o),
    .sop_o   (sop_o),
    .eop_o   (eop_o)
  );

  AST_VALID_ONLY_LOCKED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> locked_o);  // R7
  AST_POS_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    locked_o |-> (pos <= pkt_len_i));  // R6
endmodule

// File: tb/ts_sync_lock_bench.sv
module ts_sync_lock_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] byte_in = '0, token = 8'h47;
  logic       valid_in = 1'b0;
  logic [3:0] lock_cnt = 4'd9, drop_cnt = 4'd9;
  logic [7:0] pkt_len = 8'd188;
  logic [7:0] data_out;
  logic       valid_out, sop_out, eop_out, locked_out;

  always #4 clk = ~clk;

  ts_sync_lock u_ts_sync_lock (
    .clk_i(clk), .rst_ni(rst_n), .byte_i(byte_in), .valid_i(valid_in),
    .token_i(token), .lock_cnt_i(lock_cnt), .drop_cnt_i(drop_cnt), .pkt_len_i(pkt_len),
    .data_o(data_out), .valid_o(valid_out), .sop_o(sop_out), .eop_o(eop_out),
    .locked_o(locked_out)
  );

  typedef struct packed {
    logic [7:0]  tok;
    logic [7:0]  len;
    logic [3:0]  lk;
    logic [3:0]  dr;
    logic [5:0]  nsync;
    logic [63:0] mask;   // bit j set: sync j carries the token
    logic        gap;
    logic [5:0]  lsync;  // sync index where lock is expected
    logic [5:0]  dsync;  // sync index where lock is expected to end
  } scen_t;

  localparam int NSCEN = 7;
  localparam int PRE   = 5;
  localparam scen_t TBL [NSCEN] = '{
    '{8'h47, 8'd188, 4'd9, 4'd9, 6'd21, 64'h0FFF, 1'b0, 6'd8,  6'd20},
    '{8'h47, 8'd188, 4'd9, 4'd9, 6'd20, 64'h07FF, 1'b1, 6'd8,  6'd19},
    '{8'hB8, 8'd16,  4'd3, 4'd2, 6'd7,  64'h001F, 1'b0, 6'd2,  6'd6},
    '{8'h47, 8'd10,  4'd1, 4'd1, 6'd4,  64'h0007, 1'b0, 6'd0,  6'd3},
    '{8'h5A, 8'd20,  4'd0, 4'd4, 6'd8,  64'h000F, 1'b1, 6'd0,  6'd7},
    '{8'h47, 8'd16,  4'd3, 4'd2, 6'd8,  64'h003B, 1'b0, 6'd5,  6'd7},
    '{8'h47, 8'd16,  4'd2, 4'd2, 6'd8,  64'h002B, 1'b0, 6'd1,  6'd7}
  };

  int n_chk = 0, n_bad = 0;

  task automatic check(input bit ok, input string tag, input string what,
                       input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  function automatic logic [7:0] gen_byte(input scen_t s, input int idx);
    logic [7:0] b;
    int off, sidx;
    b = 8'(idx * 7 + 3);
    if (b == s.tok) b = b ^ 8'h01;
    if (idx >= PRE) begin
      off  = (idx - PRE) % int'(s.len);
      sidx = (idx - PRE) / int'(s.len);
      if (off == 0 && sidx < int'(s.nsync))
        b = s.mask[sidx] ? s.tok : ~s.tok;
    end
    return b;
  endfunction

  task automatic run_scen(input scen_t s, input int id);
    int len, nb, idx, cyc, last, rise, fall, off, sidx;
    int err_v, err_d, err_m, pre_out, gap_out;
    bit prev_v, ev, es, ee;
    logic [7:0] last_b;
    string ltag;
    len = int'(s.len);
    nb  = PRE + int'(s.nsync) * len + 4;
    rst_n = 1'b0; valid_in = 1'b0;
    token = s.tok; pkt_len = s.len; lock_cnt = s.lk; drop_cnt = s.dr;
    repeat (2) @(negedge clk);
    // R1: reset state
    check({locked_out, valid_out, sop_out, eop_out} == 4'b0, "R1", "outputs in reset",
          int'({locked_out, valid_out, sop_out, eop_out}), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check({locked_out, valid_out, sop_out, eop_out} == 4'b0, "R1", "outputs after reset",
          int'({locked_out, valid_out, sop_out, eop_out}), 0);
    idx = 0; cyc = 0; last = -1; rise = -1; fall = -1; prev_v = 1'b0; last_b = '0;
    err_v = 0; err_d = 0; err_m = 0; pre_out = 0; gap_out = 0;
    forever begin
      if (cyc != 0) @(negedge clk);
      if (prev_v) begin
        off  = (last >= PRE) ? (last - PRE) % len : -1;
        sidx = (last >= PRE) ? (last - PRE) / len : -1;
        ev = (last >= PRE) && sidx >= int'(s.lsync) && sidx < int'(s.dsync);
        es = ev && off == 0;
        ee = ev && off == len - 1;
        if (valid_out != ev) err_v++;
        if (ev && valid_out && data_out != last_b) err_d++;
        if (sop_out != es || eop_out != ee) err_m++;
        if (last < PRE && (valid_out || locked_out)) pre_out++;
      end else if (cyc != 0 && (valid_out || sop_out || eop_out)) begin
        gap_out++;
      end
      if (locked_out && rise < 0) rise = last;
      if (!locked_out && rise >= 0 && fall < 0) fall = last;
      if (idx == nb) break;
      if (s.gap && (cyc % 3 == 2)) begin
        valid_in = 1'b0; byte_in = s.tok; prev_v = 1'b0;
      end else begin
        valid_in = 1'b1; byte_in = gen_byte(s, idx);
        last = idx; last_b = byte_in; idx++; prev_v = 1'b1;
      end
      cyc++;
    end
    valid_in = 1'b0;
    case (id)
      5:       ltag = "R4";
      2, 3, 4: ltag = "R10";
      default: ltag = "R3";
    endcase
    check(rise == PRE + int'(s.lsync) * len, ltag, $sformatf("lock byte index scen %0d", id),
          rise, PRE + int'(s.lsync) * len);
    check(fall == PRE + int'(s.dsync) * len, "R8", $sformatf("drop byte index scen %0d", id),
          fall, PRE + int'(s.dsync) * len);
    check(err_v == 0, "R7", $sformatf("output window scen %0d", id), err_v, 0);
    check(err_d == 0, "R5", $sformatf("data passthrough scen %0d", id), err_d, 0);
    check(err_m == 0, "R6", $sformatf("packet markers scen %0d", id), err_m, 0);
    check(pre_out == 0, "R2", $sformatf("no output while hunting scen %0d", id), pre_out, 0);
    if (s.gap)
      check(gap_out == 0, "R9", $sformatf("idle cycles ignored scen %0d", id), gap_out, 0);
  endtask

  initial begin
    for (int i = 0; i < NSCEN; i++) run_scen(TBL[i], i);
    // R8 directed: missed sync while locked still emitted as sop (scen 6 byte at sync 2)
    begin
      scen_t s;
      s = TBL[6];
      rst_n = 1'b0; token = s.tok; pkt_len = s.len; lock_cnt = s.lk; drop_cnt = s.dr;
      @(negedge clk); rst_n = 1'b1;
      for (int k = 0; k < PRE + 2 * 16 + 1; k++) begin
        @(negedge clk); valid_in = 1'b1; byte_in = gen_byte(s, k);
      end
      @(negedge clk); valid_in = 1'b0;
      check(locked_out && valid_out && sop_out, "R8", "missed sync still sop",
            int'({locked_out, valid_out, sop_out}), 7);
      check(data_out == ~s.tok, "R8", "missed sync byte passed", int'(data_out), int'(~s.tok));
    end
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual %0d cycles expected fewer", 150000);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule